// File: doc/BRIEF.md
# Matrix Multiply Index Sequencer

This block is a nested-loop address sequencer for a small matrix multiply. It lets one repeated multiply-accumulate operation cover a whole product C += A x B. A is X rows by K columns, B is K rows by Y columns, and C is X rows by Y columns. All three matrices sit in row-major order at element offsets. Each step the block produces is one term C[i][j] += A[i][k] * B[k][j]. For that step it gives the element offsets of the three operands. The downstream datapath does the arithmetic; this block only supplies the indices.

Before a run, software sets the inputs:
- the three dimension sizes, which need not be powers of two;
- a 3-bit nesting-order code that picks which of i, k and j is the outer, middle and inner loop;
- one reverse flag per dimension.

A start pulse latches these inputs and clears the loop counters. The block then presents one triple per cycle on a valid/ready handshake and flags the final triple. If the configuration asks for more than 127 steps, has a zero size or uses an unused order code, it is refused: an error flag is raised and no triple is produced.

Top module: `mmx_index_seq`

## Requirements
- R1: Each of X, K and Y may be any value from 1 upward, including values that are not powers of two. A run presents exactly X*K*Y triples, and each (i,k,j) combination appears exactly once.
- R2: The order code selects the loops as outer/middle/inner as follows: 0 = k,i,j; 1 = k,j,i; 2 = i,k,j; 3 = j,k,i; 4 = i,j,k; 5 = j,i,k. The inner counter steps on every accepted triple. A level steps when the level inside it wraps from its maximum back to 0.
- R3: A set reverse flag makes that dimension's index run from size-1 down to 0 instead of from 0 upward. Each dimension has its own flag (X, K and Y separately).
- R4: A start is refused when X*K*Y exceeds 127, when any size is 0, or when the order code is 6 or 7. A refused start leaves cfg_err high and valid low until the next start or reset. An accepted start clears cfg_err.
- R5: While valid is high, the outputs are ofs_a = i*K+k, ofs_b = k*Y+j and ofs_c = i*Y+j.
- R6: Under order code 0 with Y greater than 1, two consecutively accepted triples never carry the same ofs_c.
- R7: A start pulse samples the sizes, order code and reverse flags. If the start is accepted, valid rises in the next cycle with the first triple. A start during a run restarts from the first triple. Configuration inputs that change while no start is present have no effect on the triples.
- R8: While valid is high and ready is low, valid and all three offsets hold unchanged.
- R9: last is high exactly on the final triple of a run. When that triple is accepted, valid drops in the next cycle.
- R10: A synchronous active-high reset drops valid and cfg_err and stops any run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a run |
| cfg_size_x | input | 7 | Rows of A and C (X) |
| cfg_size_k | input | 7 | Shared inner dimension (K) |
| cfg_size_y | input | 7 | Columns of B and C (Y) |
| cfg_order | input | 3 | Loop nesting order code |
| cfg_rev_x | input | 1 | Reverse the i index |
| cfg_rev_k | input | 1 | Reverse the k index |
| cfg_rev_y | input | 1 | Reverse the j index |
| ready | input | 1 | Consumer accepts the current triple |
| valid | output | 1 | A triple is presented |
| ofs_a | output | 7 | Element offset into A |
| ofs_b | output | 7 | Element offset into B |
| ofs_c | output | 7 | Element offset into C |
| last | output | 1 | Current triple is the final one |
| cfg_err | output | 1 | Last start was refused |

## Verification
The reference model expands every configuration into its full list of triples by plain nested loops. The bench then compares the design's output against that list on every cycle.

The shape 2x3x5 is run under all six order codes. This separates the permutations, because any two codes give a different triple sequence for that shape.

Reverse-flag combinations on a non-square shape show whether each flag acts on its own dimension only. A stalling ready pattern separates holding from advancing. The size limits 127 and 128, a zero size, an unused order code, changes to the configuration inputs in mid-run, a restart and a mid-run reset each test one refusal or override rule.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  typedef enum logic [1:0] {
    DIM_I = 2'd0,
    DIM_K = 2'd1,
    DIM_J = 2'd2
  } dim_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

  localparam int NLVL       = 3;
  localparam int NUM_ORDERS = 6;

  // Packed {outer, middle, inner} dimension codes for one order code.
  function automatic logic [5:0] order_map(input logic [2:0] ord);
    case (ord)
      3'd1:    return {DIM_K, DIM_J, DIM_I};
      3'd2:    return {DIM_I, DIM_K, DIM_J};
      3'd3:    return {DIM_J, DIM_K, DIM_I};
      3'd4:    return {DIM_I, DIM_J, DIM_K};
      3'd5:    return {DIM_J, DIM_I, DIM_K};
      default: return {DIM_K, DIM_I, DIM_J};
    endcase
  endfunction

  // Dimension driven by a loop level (0 outer .. 2 inner).
  function automatic dim_e level_dim(input logic [2:0] ord, input int lvl);
    logic [5:0] m;
    m = order_map(ord);
    case (lvl)
      0:       return dim_e'(m[5:4]);
      1:       return dim_e'(m[3:2]);
      default: return dim_e'(m[1:0]);
    endcase
  endfunction

  // Loop level that drives a dimension.
  function automatic int level_of(input logic [2:0] ord, input dim_e d);
    for (int l = 0; l < NLVL; l++) begin
      if (level_dim(ord, l) == d) return l;
    end
    return 0;
  endfunction

  // Counter value to index, with optional reversal.
  function automatic int place(input int cnt, input int size, input logic rev);
    return rev ? (size - 1 - cnt) : cnt;
  endfunction

  // Row-major element offset.
  function automatic int row_major(input int r, input int ncols, input int c);
    return r * ncols + c;
  endfunction

endpackage

// File: rtl/mmx_cfg_check.sv
module mmx_cfg_check
  import mmx_pkg::*;
#(
  parameter int DIM_W   = 7,
  parameter int MAX_OPS = 127
) (
  input  logic [DIM_W-1:0] size_x,
  input  logic [DIM_W-1:0] size_k,
  input  logic [DIM_W-1:0] size_y,
  input  logic [2:0]       order,
  output logic             ok
);

  localparam int PROD_W = 3 * DIM_W;

  logic [PROD_W-1:0] total;
  logic              size_ok;
  logic              order_ok;

  always_comb begin
    total    = PROD_W'(size_x) * PROD_W'(size_k) * PROD_W'(size_y);
    size_ok  = (total != '0) && (total <= PROD_W'(MAX_OPS));
    order_ok = (order < 3'(NUM_ORDERS));
    ok       = size_ok && order_ok;
  end

endmodule

// File: rtl/mmx_loop_ctr.sv
module mmx_loop_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max,
  output logic             carry
);

  assign at_max = (cnt == limit);
  assign carry  = step & at_max;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= at_max ? '0 : cnt + 1'b1;
    end
  end

  // R1: a stepping counter never sits past its wrap point
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |-> (cnt <= limit));

endmodule

// File: rtl/mmx_ofs_calc.sv
module mmx_ofs_calc
  import mmx_pkg::*;
#(
  parameter int DIM_W = 7,
  parameter int OFS_W = 7
) (
  input  logic [NLVL-1:0][DIM_W-1:0] lvl_cnt,
  input  logic [2:0]                 order,
  input  logic [DIM_W-1:0]           size_x,
  input  logic [DIM_W-1:0]           size_k,
  input  logic [DIM_W-1:0]           size_y,
  input  logic                       rev_x,
  input  logic                       rev_k,
  input  logic                       rev_y,
  output logic [OFS_W-1:0]           ofs_a,
  output logic [OFS_W-1:0]           ofs_b,
  output logic [OFS_W-1:0]           ofs_c
);

  int idx_i, idx_k, idx_j;

  always_comb begin
    idx_i = place(int'(lvl_cnt[level_of(order, DIM_I)]), int'(size_x), rev_x);
    idx_k = place(int'(lvl_cnt[level_of(order, DIM_K)]), int'(size_k), rev_k);
    idx_j = place(int'(lvl_cnt[level_of(order, DIM_J)]), int'(size_y), rev_y);
    ofs_a = OFS_W'(row_major(idx_i, int'(size_k), idx_k));
    ofs_b = OFS_W'(row_major(idx_k, int'(size_y), idx_j));
    ofs_c = OFS_W'(row_major(idx_i, int'(size_y), idx_j));
  end

endmodule

// File: rtl/mmx_index_seq.sv
module mmx_index_seq
  import mmx_pkg::*;
#(
  parameter int DIM_W   = 7,
  parameter int OFS_W   = 7,
  parameter int MAX_OPS = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] cfg_size_x,
  input  logic [DIM_W-1:0] cfg_size_k,
  input  logic [DIM_W-1:0] cfg_size_y,
  input  logic [2:0]       cfg_order,
  input  logic             cfg_rev_x,
  input  logic             cfg_rev_k,
  input  logic             cfg_rev_y,
  input  logic             ready,
  output logic             valid,
  output logic [OFS_W-1:0] ofs_a,
  output logic [OFS_W-1:0] ofs_b,
  output logic [OFS_W-1:0] ofs_c,
  output logic             last,
  output logic             cfg_err
);

  // Latched configuration
  logic [DIM_W-1:0] sx_q, sk_q, sy_q;
  logic [2:0]       ord_q;
  logic             rx_q, rk_q, ry_q;
  st_e              st_q;
  logic             err_q;

  // Named internal events
  logic                        cfg_ok;
  logic                        adv;
  logic                        wrap_all;
  logic [NLVL-1:0]             step_v;
  logic [NLVL-1:0]             carry_v;
  logic [NLVL-1:0]             max_v;
  logic [NLVL-1:0][DIM_W-1:0]  lvl_cnt;
  logic [NLVL-1:0][DIM_W-1:0]  lvl_lim;

  mmx_cfg_check #(.DIM_W(DIM_W), .MAX_OPS(MAX_OPS)) u_cfg (
    .size_x (cfg_size_x),
    .size_k (cfg_size_k),
    .size_y (cfg_size_y),
    .order  (cfg_order),
    .ok     (cfg_ok)
  );

  assign valid    = (st_q == ST_RUN);
  assign adv      = valid & ready;
  assign last     = valid & (&max_v);
  assign wrap_all = carry_v[0];
  assign cfg_err  = err_q;

  // Per-level wrap limits follow the latched order
  always_comb begin
    for (int l = 0; l < NLVL; l++) begin
      case (level_dim(ord_q, l))
        DIM_I:   lvl_lim[l] = sx_q - 1'b1;
        DIM_K:   lvl_lim[l] = sk_q - 1'b1;
        default: lvl_lim[l] = sy_q - 1'b1;
      endcase
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (l == NLVL - 1) begin : g_inner
      assign step_v[l] = adv;
    end else begin : g_outer
      assign step_v[l] = carry_v[l+1];
    end
    mmx_loop_ctr #(.CNT_W(DIM_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .clear  (start),
      .step   (step_v[l]),
      .limit  (lvl_lim[l]),
      .cnt    (lvl_cnt[l]),
      .at_max (max_v[l]),
      .carry  (carry_v[l])
    );
  end

  mmx_ofs_calc #(.DIM_W(DIM_W), .OFS_W(OFS_W)) u_ofs (
    .lvl_cnt (lvl_cnt),
    .order   (ord_q),
    .size_x  (sx_q),
    .size_k  (sk_q),
    .size_y  (sy_q),
    .rev_x   (rx_q),
    .rev_k   (rk_q),
    .rev_y   (ry_q),
    .ofs_a   (ofs_a),
    .ofs_b   (ofs_b),
    .ofs_c   (ofs_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
      sx_q  <= '0;
      sk_q  <= '0;
      sy_q  <= '0;
      ord_q <= '0;
      rx_q  <= 1'b0;
      rk_q  <= 1'b0;
      ry_q  <= 1'b0;
    end else if (start) begin
      sx_q  <= cfg_size_x;
      sk_q  <= cfg_size_k;
      sy_q  <= cfg_size_y;
      ord_q <= cfg_order;
      rx_q  <= cfg_rev_x;
      rk_q  <= cfg_rev_k;
      ry_q  <= cfg_rev_y;
      st_q  <= cfg_ok ? ST_RUN : ST_IDLE;
      err_q <= ~cfg_ok;
    end else if (wrap_all) begin
      st_q  <= ST_IDLE;
    end
  end

  // R4: a refused configuration never presents a triple
  a_r4_err_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !valid);

  // R5: C offset stays inside the latched X*Y matrix
  a_r5_c_in_range: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(ofs_c) < int'(sx_q) * int'(sy_q)));

  // R6: default order never repeats a C element back to back
  a_r6_default_c_moves: assert property (@(posedge clk) disable iff (rst)
    (adv && !last && !start && ord_q == 3'd0 && sy_q > 1) |=>
      (ofs_c != $past(ofs_c)));

  // R7: an accepted start presents a triple next cycle
  a_r7_start_runs: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_ok) |=> valid);

  // R8: stalled triple holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !start) |=>
      (valid && $stable(ofs_a) && $stable(ofs_b) && $stable(ofs_c)));

  // R9: accepted final triple ends the run
  a_r9_last_ends: assert property (@(posedge clk) disable iff (rst)
    (adv && last && !start) |=> !valid);

endmodule

// File: tb/test_mmx_index_seq.sv
module test_mmx_index_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [6:0] cfg_size_x = 7'd1, cfg_size_k = 7'd1, cfg_size_y = 7'd1;
  logic [2:0] cfg_order = 3'd0;
  logic       cfg_rev_x = 1'b0, cfg_rev_k = 1'b0, cfg_rev_y = 1'b0;
  logic       ready = 1'b0;
  logic       valid, last, cfg_err;
  logic [6:0] ofs_a, ofs_b, ofs_c;

  always #2 clk = ~clk;

  mmx_index_seq i_mmx_index_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_size_x(cfg_size_x), .cfg_size_k(cfg_size_k), .cfg_size_y(cfg_size_y),
    .cfg_order(cfg_order), .cfg_rev_x(cfg_rev_x), .cfg_rev_k(cfg_rev_k),
    .cfg_rev_y(cfg_rev_y), .ready(ready), .valid(valid),
    .ofs_a(ofs_a), .ofs_b(ofs_b), .ofs_c(ofs_c), .last(last), .cfg_err(cfg_err)
  );

  int    qa[$], qb[$], qc[$];
  bit    err_m = 1'b0;
  int    compared = 0, mismatched = 0;
  string tag = "R10";
  bit    done = 1'b0;

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference: expand the whole run into triples with plain loops
  task automatic build(int x, int k, int y, int ord, bit rx, bit rk, bit ry);
    int sz[3];
    int dimat[3];
    int v[3];
    int ii, kk, jj;
    qa.delete(); qb.delete(); qc.delete();
    sz[0] = x; sz[1] = k; sz[2] = y;
    case (ord)
      0: dimat = '{1, 0, 2};
      1: dimat = '{1, 2, 0};
      2: dimat = '{0, 1, 2};
      3: dimat = '{2, 1, 0};
      4: dimat = '{0, 2, 1};
      5: dimat = '{2, 0, 1};
      default: dimat = '{0, 1, 2};
    endcase
    if (ord > 5 || x * k * y == 0 || x * k * y > 127) begin
      err_m = 1'b1;
      return;
    end
    err_m = 1'b0;
    for (int p = 0; p < sz[dimat[0]]; p++)
      for (int q = 0; q < sz[dimat[1]]; q++)
        for (int r = 0; r < sz[dimat[2]]; r++) begin
          v[dimat[0]] = p; v[dimat[1]] = q; v[dimat[2]] = r;
          ii = rx ? x - 1 - v[0] : v[0];
          kk = rk ? k - 1 - v[1] : v[1];
          jj = ry ? y - 1 - v[2] : v[2];
          qa.push_back(ii * k + kk);
          qb.push_back(kk * y + jj);
          qc.push_back(ii * y + jj);
        end
  endtask

  // One clock: compare at negedge, then drive and advance the model
  task automatic cyc(bit st, bit rdy);
    @(negedge clk);
    chk("valid", int'(valid), int'(qa.size() > 0));
    chk("cfg_err", int'(cfg_err), int'(err_m));
    if (qa.size() > 0 && valid) begin
      chk("ofs_a", int'(ofs_a), qa[0]);
      chk("ofs_b", int'(ofs_b), qb[0]);
      chk("ofs_c", int'(ofs_c), qc[0]);
      chk("last", int'(last), int'(qa.size() == 1));
    end
    start = st;
    ready = rdy;
    if (st) begin
      build(int'(cfg_size_x), int'(cfg_size_k), int'(cfg_size_y), int'(cfg_order),
            cfg_rev_x, cfg_rev_k, cfg_rev_y);
    end else if (rdy && qa.size() > 0) begin
      void'(qa.pop_front()); void'(qb.pop_front()); void'(qc.pop_front());
    end
  endtask

  task automatic setcfg(int x, int k, int y, int o, bit rx, bit rk, bit ry);
    cfg_size_x = 7'(x); cfg_size_k = 7'(k); cfg_size_y = 7'(y);
    cfg_order = 3'(o); cfg_rev_x = rx; cfg_rev_k = rk; cfg_rev_y = ry;
  endtask

  task automatic launch(int x, int k, int y, int o, bit rx, bit rk, bit ry);
    setcfg(x, k, y, o, rx, rk, ry);
    cyc(1'b1, 1'b1);
  endtask

  task automatic drain(bit stall);
    int guard = 0;
    while (qa.size() > 0 && guard < 1000) begin
      cyc(1'b0, stall ? ($urandom % 3 != 0) : 1'b1);
      guard++;
    end
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    qa.delete(); qb.delete(); qc.delete();
    err_m = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    tag = "R10 reset state";
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);

    tag = "R5 R6 default order 3x4x2";
    launch(3, 4, 2, 0, 0, 0, 0);
    drain(1'b0);

    tag = "R1 non-power-two 3x5x7";
    launch(3, 5, 7, 0, 0, 0, 0);
    drain(1'b0);

    tag = "R2 order sweep 2x3x5";
    for (int o = 0; o < 6; o++) begin
      launch(2, 3, 5, o, 0, 0, 0);
      drain(1'b0);
    end

    tag = "R3 reverse flags 3x2x4";
    for (int m = 1; m < 8; m++) begin
      launch(3, 2, 4, m % 6, m[0], m[1], m[2]);
      drain(1'b0);
    end

    tag = "R8 stalled ready";
    launch(4, 3, 3, 2, 1, 0, 1);
    drain(1'b1);
    launch(2, 5, 3, 5, 0, 1, 0);
    drain(1'b1);

    tag = "R4 limit 127 accepted";
    launch(1, 127, 1, 4, 0, 1, 0);
    drain(1'b0);
    tag = "R4 over limit 128 refused";
    launch(8, 4, 4, 0, 0, 0, 0);
    drain(1'b0);
    tag = "R4 zero size refused";
    launch(3, 0, 3, 0, 0, 0, 0);
    drain(1'b0);
    tag = "R4 order code 6 refused";
    launch(2, 2, 2, 6, 0, 0, 0);
    drain(1'b0);
    tag = "R4 accepted start clears error";
    launch(2, 2, 2, 1, 0, 0, 0);
    drain(1'b0);

    tag = "R9 single element";
    launch(1, 1, 1, 3, 1, 1, 1);
    drain(1'b0);

    tag = "R7 config change mid-run ignored";
    launch(3, 3, 3, 0, 0, 0, 0);
    cyc(1'b0, 1'b1);
    setcfg(9, 9, 9, 7, 1, 1, 1);
    drain(1'b0);

    tag = "R7 restart mid-run";
    launch(4, 2, 3, 1, 0, 0, 0);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b0, 1'b0);
    launch(2, 4, 2, 3, 1, 0, 0);
    drain(1'b0);

    tag = "R10 reset mid-run";
    launch(5, 5, 5, 2, 0, 0, 0);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    do_reset();
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule